// File: doc/BRIEF.md
# Paged Boot Memory Decoder

This block sits between a processor bus and a banked program store. It turns memory reads that fall inside a 32 KB ROM window into one chip enable, for either an on-board ROM or a plug-in external ROM of 1 Mbit (four pages of 32 KB). A small page register, written through an I/O port, supplies the two upper ROM address lines. The lower fifteen address bits pass straight through.

An active-low presence-detect line reports that the external module is attached. The line is brought into the clock domain through a two-stage synchroniser. Once it reads as present, the on-board enable is held off and the external enable is used instead. The block also produces a wait-state request for every ROM access. The length of that request depends on which ROM serves the access. Finally, it produces an active-low DAC strobe that covers an I/O write to the DAC port. This block's strobe is the only one, so when a module is attached it takes priority over anything the module could produce.

Top module: `paged_rom_decoder`

## Requirements
- R1: After reset the page register holds page 0, so `rom_page_o` reads 2'b00.
- R2: A rising edge of `wr_i` (low in the previous cycle, high now) with `io_i`=1 and `addr_i`=16'h0040 loads `wdata_i[1:0]` into the page register. The new value is seen from the next cycle on. Data bits [7:2] are ignored.
- R3: `rom_ofs_o` always equals `addr_i[14:0]`, and `rom_page_o` always equals the page register.
- R4: A ROM access is a cycle with `rd_i`=1, `io_i`=0 and `addr_i[15]`=1. Exactly one ROM enable is low during a ROM access. Both are high in every other cycle, including memory reads below 16'h8000 and I/O reads.
- R5: A change on `mod_det_n_i` reaches the selects two clock edges after it is driven, and not earlier.
- R6: While the synchronised detect reads present (low), `int_rom_ce_n_o` stays high and ROM accesses drive `ext_rom_ce_n_o` low.
- R7: `wait_o` is high for the first INT_WAIT (default 1) cycles of an on-board access, or the first EXT_WAIT (default 2) cycles of an external access. It is low after that and outside ROM accesses. The ROM is chosen by the detect state in the first cycle of the access.
- R8: `dac_stb_n_o` is low exactly in the cycles with `io_i`=1, `wr_i`=1 and `addr_i`=16'h0050.
- R9: Keeping `wr_i` high at the page port for further cycles does not reload the page, even when the data changes. Memory-space writes to 16'h0040 do not change the page either.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_i | input | 16 | Processor address |
| wdata_i | input | 8 | Processor write data |
| rd_i | input | 1 | Read strobe, active high |
| wr_i | input | 1 | Write strobe, active high |
| io_i | input | 1 | 1 = I/O space, 0 = memory space |
| mod_det_n_i | input | 1 | External module presence, low when attached (asynchronous) |
| rom_page_o | output | 2 | Upper ROM address lines from the page register |
| rom_ofs_o | output | 15 | Lower ROM address lines |
| int_rom_ce_n_o | output | 1 | On-board ROM enable, active low |
| ext_rom_ce_n_o | output | 1 | External ROM enable, active low |
| wait_o | output | 1 | Wait-state request |
| dac_stb_n_o | output | 1 | DAC strobe, active low |

## Verification
The bench holds the write strobe high across a change of data at the page port. A decoder that reacts to the level instead of the edge would take the second value. It also writes to the page address in memory space and to the DAC port, which a loose address decode would treat as page writes. The detect line is dropped in the middle of a long read, and the bench checks the exact cycle the enable moves from on-board to external. A missing or extra synchroniser stage would switch one cycle off. Reads just below the window, and I/O reads inside it, confirm that no enable and no wait request leak out. Back-to-back accesses on both ROMs check that the wait request lasts the right length for each source and is not cut short or stretched.

// File: rtl/prd_pkg.sv
package prd_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int PAGE_W = 2;
  localparam int OFS_W  = 15;

  // True when a cycle is a memory read inside the ROM window (top address bit set)
  function automatic logic rom_hit(input logic [ADDR_W-1:0] a, input logic rd,
                                   input logic io);
    return rd && !io && a[ADDR_W-1];
  endfunction

  // True when an I/O cycle targets the given port
  function automatic logic port_hit(input logic [ADDR_W-1:0] a, input logic io,
                                    input logic [ADDR_W-1:0] port);
    return io && (a == port);
  endfunction
endpackage

// File: rtl/prd_det_sync.sv
module prd_det_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic det_n_i,
  output logic present_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= {chain_q[STAGES-2:0], det_n_i};
  end

  assign present_o = !chain_q[STAGES-1];
endmodule

// File: rtl/prd_page_reg.sv
module prd_page_reg
  import prd_pkg::*;
#(
  parameter logic [ADDR_W-1:0] PAGE_PORT = 16'h0040
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [PAGE_W-1:0] data_i,
  input  logic              wr_i,
  input  logic              io_i,
  output logic [PAGE_W-1:0] page_o
);
  logic wr_q;
  logic load_w;

  assign load_w = wr_i && !wr_q && port_hit(addr_i, io_i, PAGE_PORT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= 1'b0;
      page_o <= '0;
    end else begin
      wr_q <= wr_i;
      if (load_w) page_o <= data_i;
    end
  end

  p_page_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !load_w |=> $stable(page_o));
  p_level_no_reload_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && $past(wr_i)) |-> !load_w);
endmodule

// File: rtl/prd_wait_gen.sv
module prd_wait_gen #(
  parameter int INT_WAIT = 1,
  parameter int EXT_WAIT = 2,
  localparam int MAXW  = (INT_WAIT > EXT_WAIT) ? INT_WAIT : EXT_WAIT,
  localparam int CNT_W = $clog2(MAXW + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rom_sel_i,
  input  logic present_i,
  output logic wait_o
);
  logic             sel_q;
  logic             start_w;
  logic [CNT_W-1:0] cnt_q;

  assign start_w = rom_sel_i && !sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      sel_q <= rom_sel_i;
      if (!rom_sel_i)        cnt_q <= '0;
      else if (start_w)      cnt_q <= present_i ? CNT_W'(EXT_WAIT - 1) : CNT_W'(INT_WAIT - 1);
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end
  end

  assign wait_o = rom_sel_i && (start_w || cnt_q != '0);

  p_wait_on_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start_w |-> wait_o);
  p_wait_only_rom_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wait_o |-> rom_sel_i);
  p_wait_bounded_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(MAXW));
endmodule

// File: rtl/paged_rom_decoder.sv
module paged_rom_decoder
  import prd_pkg::*;
#(
  parameter logic [ADDR_W-1:0] PAGE_PORT = 16'h0040,
  parameter logic [ADDR_W-1:0] DAC_PORT  = 16'h0050,
  parameter int                INT_WAIT  = 1,
  parameter int                EXT_WAIT  = 2,
  parameter int                SYNC_STG  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic              io_i,
  input  logic              mod_det_n_i,
  output logic [PAGE_W-1:0] rom_page_o,
  output logic [OFS_W-1:0]  rom_ofs_o,
  output logic              int_rom_ce_n_o,
  output logic              ext_rom_ce_n_o,
  output logic              wait_o,
  output logic              dac_stb_n_o
);
  logic present_w;
  logic rom_sel_w;
  logic unused_data;

  assign unused_data = ^wdata_i[DATA_W-1:PAGE_W];

  prd_det_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_n), .det_n_i(mod_det_n_i), .present_o(present_w));

  prd_page_reg #(.PAGE_PORT(PAGE_PORT)) u_page (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .data_i(wdata_i[PAGE_W-1:0]),
    .wr_i(wr_i), .io_i(io_i), .page_o(rom_page_o));

  assign rom_sel_w = rom_hit(addr_i, rd_i, io_i);

  prd_wait_gen #(.INT_WAIT(INT_WAIT), .EXT_WAIT(EXT_WAIT)) u_wait (
    .clk(clk), .rst_n(rst_n), .rom_sel_i(rom_sel_w), .present_i(present_w),
    .wait_o(wait_o));

  assign rom_ofs_o      = addr_i[OFS_W-1:0];
  assign int_rom_ce_n_o = !(rom_sel_w && !present_w);
  assign ext_rom_ce_n_o = !(rom_sel_w && present_w);
  assign dac_stb_n_o    = !(wr_i && port_hit(addr_i, io_i, DAC_PORT));

  p_one_ce_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({!int_rom_ce_n_o, !ext_rom_ce_n_o}) <= 1);
  p_ce_in_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!int_rom_ce_n_o || !ext_rom_ce_n_o) |-> (rd_i && !io_i && addr_i[ADDR_W-1]));
  p_int_off_present_r6: assert property (@(posedge clk) disable iff (!rst_n)
    present_w |-> int_rom_ce_n_o);
  p_dac_io_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_stb_n_o |-> (wr_i && io_i && addr_i == DAC_PORT));
endmodule

// File: tb/paged_rom_decoder_bench.sv
module paged_rom_decoder_bench;
  localparam time CLK_HALF = 10ns;
  localparam int  INT_W = 1;
  localparam int  EXT_W = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic rd = 1'b0, wr = 1'b0, io = 1'b0, det_n = 1'b1;
  logic [1:0]  page_o;
  logic [14:0] ofs_o;
  logic ice_n, ece_n, wt, dac_n;

  always #(CLK_HALF) clk = ~clk;

  paged_rom_decoder u_paged_rom_decoder (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .wdata_i(wdata), .rd_i(rd),
    .wr_i(wr), .io_i(io), .mod_det_n_i(det_n), .rom_page_o(page_o),
    .rom_ofs_o(ofs_o), .int_rom_ce_n_o(ice_n), .ext_rom_ce_n_o(ece_n),
    .wait_o(wt), .dac_stb_n_o(dac_n));

  typedef struct packed {
    logic [1:0]  pg;
    logic [14:0] ofs;
    logic        ice, ece, wt, dac;
  } exp_t;

  exp_t  exp_q[$];
  string req_q[$];
  int checks = 0, fails = 0;
  logic  done = 1'b0;

  // Reference model state (value after the next clock edge)
  logic [1:0] m_page;
  logic       m_d1, m_d2, m_prev_wr, m_prev_rom;
  int         m_acc, m_need;
  logic       det_req = 1'b1;

  // Monitor: pops one expectation per checked cycle
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      exp_t a;
      string r;
      e = exp_q.pop_front();
      r = req_q.pop_front();
      a = '{pg: page_o, ofs: ofs_o, ice: ice_n, ece: ece_n, wt: wt, dac: dac_n};
      checks++;
      if (a !== e) begin
        fails++;
        $display("FAIL %s: got pg=%0d ofs=%h ice=%b ece=%b wait=%b dac=%b, expected pg=%0d ofs=%h ice=%b ece=%b wait=%b dac=%b",
                 r, a.pg, a.ofs, a.ice, a.ece, a.wt, a.dac,
                 e.pg, e.ofs, e.ice, e.ece, e.wt, e.dac);
      end
    end
  end

  // Driver: one bus cycle, pushes the expectation when chk is set
  task automatic cyc(input logic [15:0] a, input logic [7:0] d, input logic i_io,
                     input logic i_rd, input logic i_wr, input logic chk,
                     input string req);
    logic rom, present, wt_e;
    exp_t e;
    @(posedge clk); #2;
    addr = a; wdata = d; io = i_io; rd = i_rd; wr = i_wr; det_n = det_req;
    present = !m_d2;
    rom = i_rd && !i_io && a[15];
    if (rom && !m_prev_rom) begin
      m_acc = 0;
      m_need = present ? EXT_W : INT_W;
    end
    wt_e = rom && (m_acc < m_need);
    e = '{pg: m_page, ofs: a[14:0], ice: !(rom && !present), ece: !(rom && present),
          wt: wt_e, dac: !(i_io && i_wr && a == 16'h0050)};
    if (chk) begin
      exp_q.push_back(e);
      req_q.push_back(req);
    end
    // state after the next edge
    if (i_io && i_wr && !m_prev_wr && a == 16'h0040) m_page = d[1:0];
    m_prev_wr  = i_wr;
    m_d2       = m_d1;
    m_d1       = det_req;
    if (rom) m_acc++;
    m_prev_rom = rom;
  endtask

  task automatic do_reset();
    @(posedge clk); #2;
    rst_n = 1'b0; rd = 0; wr = 0; io = 0;
    repeat (2) @(posedge clk);
    #2 rst_n = 1'b1;
    m_page = '0; m_d1 = det_req; m_d2 = 1'b1;
    m_prev_wr = 1'b0; m_prev_rom = 1'b0; m_acc = 0; m_need = INT_W;
  endtask

  initial begin
    #(CLK_HALF * 2 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1: reset state
    cyc(16'h0000, 8'h00, 0, 0, 0, 1, "R1 reset idle");
    cyc(16'h8123, 8'h00, 0, 1, 0, 1, "R1 R3 R7 first read on-board");
    cyc(16'h8123, 8'h00, 0, 1, 0, 1, "R7 on-board wait dropped");
    cyc(16'h0000, 8'h00, 0, 0, 0, 1, "R4 idle");
    // R2: page write, upper data bits ignored
    cyc(16'h0040, 8'hFE, 1, 0, 1, 1, "R2 page write cycle");
    cyc(16'h0040, 8'h01, 1, 0, 1, 1, "R9 strobe held, new data");
    cyc(16'h0040, 8'h01, 1, 0, 1, 1, "R9 strobe still held");
    cyc(16'h0000, 8'h00, 0, 0, 0, 1, "R2 page now 2");
    cyc(16'hFFFF, 8'h00, 0, 1, 0, 1, "R3 top of window");
    cyc(16'h0000, 8'h00, 0, 0, 0, 0, "");
    // R8: DAC strobe, not a page write
    cyc(16'h0050, 8'h03, 1, 0, 1, 1, "R8 DAC strobe low");
    cyc(16'h0051, 8'h03, 1, 0, 1, 1, "R8 neighbour port");
    cyc(16'h0050, 8'h03, 0, 0, 1, 1, "R8 memory write to DAC addr");
    cyc(16'h0000, 8'h00, 0, 0, 0, 0, "");
    cyc(16'h0040, 8'h03, 0, 0, 1, 1, "R9 memory write to page addr");
    cyc(16'h0000, 8'h00, 0, 0, 0, 1, "R9 page still 2");
    // R4: outside window
    cyc(16'h7FFF, 8'h00, 0, 1, 0, 1, "R4 read below window");
    cyc(16'h8000, 8'h00, 1, 1, 0, 1, "R4 I/O read in window range");
    cyc(16'h0000, 8'h00, 0, 0, 0, 0, "");
    // R5/R6: detect drops in a long read
    cyc(16'h8400, 8'h00, 0, 1, 0, 1, "R7 long read start");
    cyc(16'h8401, 8'h00, 0, 1, 0, 1, "R7 long read");
    det_req = 1'b0;
    cyc(16'h8402, 8'h00, 0, 1, 0, 1, "R5 detect driven, still on-board");
    cyc(16'h8403, 8'h00, 0, 1, 0, 1, "R5 one edge, still on-board");
    cyc(16'h8404, 8'h00, 0, 1, 0, 1, "R5 R6 two edges, external");
    cyc(16'h0000, 8'h00, 0, 0, 0, 1, "R4 idle after read");
    // R6/R7: external accesses, back to back
    cyc(16'h9000, 8'h00, 0, 1, 0, 1, "R6 R7 external first cycle");
    cyc(16'h9000, 8'h00, 0, 1, 0, 1, "R7 external second wait");
    cyc(16'h9000, 8'h00, 0, 1, 0, 1, "R7 external wait dropped");
    cyc(16'h7000, 8'h00, 0, 1, 0, 1, "R4 gap below window");
    cyc(16'hA000, 8'h00, 0, 1, 0, 1, "R7 next external start");
    cyc(16'hA001, 8'h00, 0, 1, 0, 1, "R7 next external second");
    cyc(16'h0040, 8'h07, 1, 0, 1, 1, "R2 page write 3");
    cyc(16'hC0DE, 8'h00, 0, 1, 0, 1, "R3 page 3 external");
    // R1: reset returns page 0 and detect restarts through the synchroniser
    do_reset();
    cyc(16'h8010, 8'h00, 0, 1, 0, 1, "R1 R5 after reset page 0, on-board");
    cyc(16'h8010, 8'h00, 0, 1, 0, 1, "R5 after reset second cycle");
    cyc(16'h0000, 8'h00, 0, 0, 0, 1, "R4 idle");
    cyc(16'h8010, 8'h00, 0, 1, 0, 1, "R6 external again");
    det_req = 1'b1;
    cyc(16'h0000, 8'h00, 0, 0, 0, 0, "");
    cyc(16'h0000, 8'h00, 0, 0, 0, 0, "");
    cyc(16'h8020, 8'h00, 0, 1, 0, 1, "R5 module removed, on-board");
    cyc(16'h0000, 8'h00, 0, 0, 0, 1, "R4 final idle");
    @(posedge clk);
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule